// File: doc/BRIEF.md
# Platform Power State Sequencer

This block steps an application processor through its platform power states: mechanical off (G3), soft off (S5), suspend (S3) and running (S0). It watches two active-low status lines from the processor, one for "held in reset" and one for "asleep". From these it works out the state the processor wants, and walks there through a set of transition states. On the way up it drives the system reset line and the power-management IC enable line. The enable line is pulsed low by the block itself. Each wait on the processor is bounded, and a timeout leads to a fallback path.

Every delay is given in milliseconds and converted to clock ticks through a ticks-per-millisecond parameter. One down-counter is shared by the sequencing waits. A second down-counter times the long hold of the enable line during a forced shutdown. A forced shutdown can be requested from outside by a companion controller, or raised internally. When it happens, the block pulls system reset low and holds the enable line low for the hold period. Both status inputs and both request inputs are expected to be synchronous to the clock already.

The current state is reported on a 4-bit code. Four one-cycle strobes mark startup, resume, suspend and shutdown events.

Top module: `pwr_seq_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `state_o` is 0 (G3), `sys_rst_n` is 0, `pmic_en_n` is 1 and all four strobes are 0.
- R2: The wanted state is decoded with this priority: `ap_rst_n`=0 means G3 whatever `ap_sleep_n` is; otherwise `ap_sleep_n`=0 means S3; otherwise S0. In G3, the block stays in G3 as long as the decoded state is G3.
- R3: State codes are: 0 G3, 1 G3-to-S5, 2 S5, 3 power-up settle, 4 enable pulse, 5 wait for reset release, 6 boot delay, 7 S3, 8 S3-to-S0, 9 S0, 10 S0-to-S3, 11 S3-to-S5, 12 S5-to-G3. From G3, a decoded state other than G3 moves the block to 1. Codes 1 and 2 each last one cycle, and the block then enters code 3.
- R4: On entry to code 3, `sys_rst_n` goes to 1. Code 3 lasts SETTLE_MS ticks. Then `pmic_en_n` is 0 for exactly PMIC_PULSE_MS ticks (code 4) and goes back to 1 on entry to code 5.
- R5: In code 5 the block waits at most RST_WAIT_MS ticks for `ap_rst_n`=1. On timeout it goes to code 12 for one cycle with no strobe, then to G3.
- R6: Once `ap_rst_n`=1 in code 5, the block spends BOOT_MS ticks in code 6. It then enters S3 with `startup_o` high for that one cycle.
- R7: In S3, a decoded G3 leads to code 11, a decoded S0 leads to code 8, and a decoded S3 keeps the block in S3.
- R8: In code 8 the block waits at most RESUME_WAIT_MS ticks for `ap_rst_n`=1. If it is seen, the block enters S0 with `resume_o` high for one cycle. On timeout, a forced shutdown starts and the block goes to code 10.
- R9: In S0, a decoded state other than S0 leads to code 10. Code 10 lasts one cycle and the block then enters S3 with `suspend_o` high for one cycle.
- R10: If `btn_held` is 1 during the cycle in code 10, a forced shutdown starts at the same edge that enters S3.
- R11: Code 11 lasts one cycle and leads to code 12 with `shutdown_o` high for one cycle. Code 12 then leads to G3.
- R12: A forced shutdown can come from `force_req`=1 in any state, from R8 or from R10. It sets `sys_rst_n` to 0 and holds `pmic_en_n` at 0 for FORCE_HOLD_MS ticks. After that the enable line returns to 1. `sys_rst_n` stays 0 until the next power-up enters code 3.
- R13: Leaving G3 for code 1 ends any hold that is still running, so `pmic_en_n` is 1 in code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ap_rst_n | input | 1 | Processor in reset, active low |
| ap_sleep_n | input | 1 | Processor asleep, active low |
| btn_held | input | 1 | Power button currently held |
| force_req | input | 1 | Forced shutdown request from the companion controller |
| sys_rst_n | output | 1 | System reset to the processor, active low |
| pmic_en_n | output | 1 | Power-management IC enable, active low |
| state_o | output | 4 | Current state code (see R3) |
| startup_o | output | 1 | One-cycle strobe on power-up into S3 |
| resume_o | output | 1 | One-cycle strobe on entry to S0 |
| suspend_o | output | 1 | One-cycle strobe on entry to S3 from S0 |
| shutdown_o | output | 1 | One-cycle strobe on leaving S3 for off |

## Verification
The assertions check the following on every cycle:
- the one-cycle transition states and the strobes that go with them;
- that the enable line is low only in the pulse state or during a hold;
- that the shared counter counts down by one.

The lengths of the settle, pulse, boot, wait and hold windows can only be shown by the bench's scenarios. The same holds for the timeout fallbacks, the button check at suspend entry and the cancelling of a hold when the block leaves G3. These scenarios are measured against a behavioural model that runs every clock.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [3:0] {
        PS_OFF       = 4'd0,
        PS_OFF_UP    = 4'd1,
        PS_SOFT      = 4'd2,
        PS_UP_SETTLE = 4'd3,
        PS_UP_PULSE  = 4'd4,
        PS_UP_WAIT   = 4'd5,
        PS_UP_BOOT   = 4'd6,
        PS_SUSP      = 4'd7,
        PS_RESUME    = 4'd8,
        PS_RUN       = 4'd9,
        PS_RUN_DN    = 4'd10,
        PS_SUSP_DN   = 4'd11,
        PS_SOFT_OFF  = 4'd12
    } pstate_e;

    typedef enum logic [1:0] {
        TGT_OFF  = 2'd0,
        TGT_SUSP = 2'd1,
        TGT_RUN  = 2'd2
    } ptarget_e;

    typedef struct packed {
        logic startup;
        logic resume;
        logic suspend;
        logic shutdown;
    } strobe_t;

    function automatic int bits_for(longint v);
        int n;
        n = 1;
        while ((64'sd1 <<< n) <= v) n++;
        return n;
    endfunction

    function automatic longint max_of(longint a, longint b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwr_seq_decode.sv
module pwr_seq_decode
    import pwr_seq_pkg::*;
(
    input  logic     ap_rst_n,
    input  logic     ap_sleep_n,
    output ptarget_e tgt
);
    always_comb begin
        if (!ap_rst_n)        tgt = TGT_OFF;
        else if (!ap_sleep_n) tgt = TGT_SUSP;
        else                  tgt = TGT_RUN;
    end
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R4
    tick_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int  WW       = 8,
    parameter int  HW       = 8,
    parameter longint N_SETTLE = 4,
    parameter longint N_PULSE  = 4,
    parameter longint N_WAIT   = 4,
    parameter longint N_BOOT   = 4,
    parameter longint N_RESUME = 4,
    parameter longint N_HOLD   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  ptarget_e      tgt,
    input  logic          ap_rst_n,
    input  logic          btn_held,
    input  logic          force_req,
    input  logic          wait_zero,
    input  logic          hold_zero,
    output logic          wait_ld,
    output logic [WW-1:0] wait_val,
    output logic          hold_ld,
    output logic [HW-1:0] hold_val,
    output pstate_e       state,
    output logic          sys_rst_n,
    output logic          pmic_en_n,
    output strobe_t       stb
);
    pstate_e state_q, nxt;
    logic    sys_rst_n_q;
    logic    seq_pmic_n_q, seq_pmic_nxt;
    logic    hold_q;
    strobe_t stb_q, stb_nxt;
    logic    force_int, force_any, rst_rel, clr_hold;

    always_comb begin
        nxt          = state_q;
        wait_ld      = 1'b0;
        wait_val     = '0;
        force_int    = 1'b0;
        rst_rel      = 1'b0;
        clr_hold     = 1'b0;
        seq_pmic_nxt = seq_pmic_n_q;
        stb_nxt      = '0;
        case (state_q)
            PS_OFF: if (tgt != TGT_OFF) begin
                nxt      = PS_OFF_UP;
                clr_hold = 1'b1;
            end
            PS_OFF_UP: nxt = PS_SOFT;
            PS_SOFT: begin
                nxt      = PS_UP_SETTLE;
                rst_rel  = 1'b1;
                wait_ld  = 1'b1;
                wait_val = WW'(N_SETTLE - 1);
            end
            PS_UP_SETTLE: if (wait_zero) begin
                nxt          = PS_UP_PULSE;
                seq_pmic_nxt = 1'b0;
                wait_ld      = 1'b1;
                wait_val     = WW'(N_PULSE - 1);
            end
            PS_UP_PULSE: if (wait_zero) begin
                nxt          = PS_UP_WAIT;
                seq_pmic_nxt = 1'b1;
                wait_ld      = 1'b1;
                wait_val     = WW'(N_WAIT - 1);
            end
            PS_UP_WAIT: begin
                if (ap_rst_n) begin
                    nxt      = PS_UP_BOOT;
                    wait_ld  = 1'b1;
                    wait_val = WW'(N_BOOT - 1);
                end else if (wait_zero) begin
                    nxt = PS_SOFT_OFF;
                end
            end
            PS_UP_BOOT: if (wait_zero) begin
                nxt             = PS_SUSP;
                stb_nxt.startup = 1'b1;
            end
            PS_SUSP: begin
                if (tgt == TGT_OFF) begin
                    nxt = PS_SUSP_DN;
                end else if (tgt == TGT_RUN) begin
                    nxt      = PS_RESUME;
                    wait_ld  = 1'b1;
                    wait_val = WW'(N_RESUME - 1);
                end
            end
            PS_RESUME: begin
                if (ap_rst_n) begin
                    nxt            = PS_RUN;
                    stb_nxt.resume = 1'b1;
                end else if (wait_zero) begin
                    nxt       = PS_RUN_DN;
                    force_int = 1'b1;
                end
            end
            PS_RUN: if (tgt != TGT_RUN) nxt = PS_RUN_DN;
            PS_RUN_DN: begin
                nxt             = PS_SUSP;
                stb_nxt.suspend = 1'b1;
                force_int       = btn_held;
            end
            PS_SUSP_DN: begin
                nxt              = PS_SOFT_OFF;
                stb_nxt.shutdown = 1'b1;
            end
            PS_SOFT_OFF: nxt = PS_OFF;
            default: begin
                nxt          = PS_OFF;
                seq_pmic_nxt = 1'b1;
            end
        endcase
        force_any = force_req | force_int;
    end

    assign hold_ld  = force_any;
    assign hold_val = HW'(N_HOLD - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= PS_OFF;
            sys_rst_n_q  <= 1'b0;
            seq_pmic_n_q <= 1'b1;
            hold_q       <= 1'b0;
            stb_q        <= '0;
        end else begin
            state_q      <= nxt;
            seq_pmic_n_q <= seq_pmic_nxt;
            stb_q        <= stb_nxt;
            if (rst_rel) sys_rst_n_q <= 1'b1;
            if (clr_hold || (hold_q && hold_zero)) hold_q <= 1'b0;
            if (force_any) begin
                sys_rst_n_q <= 1'b0;
                hold_q      <= 1'b1;
            end
        end
    end

    assign state     = state_q;
    assign sys_rst_n = sys_rst_n_q;
    assign pmic_en_n = seq_pmic_n_q & ~hold_q;
    assign stb       = stb_q;

    // R3
    off_up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_OFF_UP) |=> (state_q == PS_SOFT));
    // R4
    pulse_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!seq_pmic_n_q) |-> (state_q == PS_UP_PULSE));
    // R6
    startup_src_chk: assert property (@(posedge clk) disable iff (rst)
        stb_q.startup |-> (state_q == PS_SUSP && $past(state_q) == PS_UP_BOOT));
    // R8
    resume_go_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_RESUME && ap_rst_n) |=> (state_q == PS_RUN && stb_q.resume));
    // R9
    suspend_go_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_RUN_DN) |=> (state_q == PS_SUSP && stb_q.suspend));
    // R11
    shutdown_go_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_SUSP_DN) |=> (state_q == PS_SOFT_OFF && stb_q.shutdown));
    // R12
    force_pins_chk: assert property (@(posedge clk) disable iff (rst)
        force_req |=> (!sys_rst_n_q && hold_q));
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int TICKS_PER_MS   = 1000,
    parameter int SETTLE_MS      = 50,
    parameter int PMIC_PULSE_MS  = 50,
    parameter int RST_WAIT_MS    = 300,
    parameter int BOOT_MS        = 500,
    parameter int RESUME_WAIT_MS = 1000,
    parameter int FORCE_HOLD_MS  = 9000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ap_rst_n,
    input  logic       ap_sleep_n,
    input  logic       btn_held,
    input  logic       force_req,
    output logic       sys_rst_n,
    output logic       pmic_en_n,
    output logic [3:0] state_o,
    output logic       startup_o,
    output logic       resume_o,
    output logic       suspend_o,
    output logic       shutdown_o
);
    localparam longint N_SETTLE = longint'(TICKS_PER_MS) * SETTLE_MS;
    localparam longint N_PULSE  = longint'(TICKS_PER_MS) * PMIC_PULSE_MS;
    localparam longint N_WAIT   = longint'(TICKS_PER_MS) * RST_WAIT_MS;
    localparam longint N_BOOT   = longint'(TICKS_PER_MS) * BOOT_MS;
    localparam longint N_RESUME = longint'(TICKS_PER_MS) * RESUME_WAIT_MS;
    localparam longint N_HOLD   = longint'(TICKS_PER_MS) * FORCE_HOLD_MS;
    localparam longint N_WMAX   = max_of(max_of(max_of(N_SETTLE, N_PULSE),
                                                max_of(N_WAIT, N_BOOT)), N_RESUME);
    localparam int WW = bits_for(N_WMAX);
    localparam int HW = bits_for(N_HOLD);

    ptarget_e      tgt;
    logic          wait_ld, hold_ld, wait_zero, hold_zero;
    logic [WW-1:0] wait_val;
    logic [HW-1:0] hold_val;
    pstate_e       st;
    strobe_t       stb;

    pwr_seq_decode u_dec (
        .ap_rst_n   (ap_rst_n),
        .ap_sleep_n (ap_sleep_n),
        .tgt        (tgt)
    );

    pwr_seq_timer #(.W(WW)) u_wait_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (wait_ld),
        .load_val (wait_val),
        .zero     (wait_zero)
    );

    pwr_seq_timer #(.W(HW)) u_hold_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (hold_ld),
        .load_val (hold_val),
        .zero     (hold_zero)
    );

    pwr_seq_fsm #(
        .WW(WW), .HW(HW),
        .N_SETTLE(N_SETTLE), .N_PULSE(N_PULSE), .N_WAIT(N_WAIT),
        .N_BOOT(N_BOOT), .N_RESUME(N_RESUME), .N_HOLD(N_HOLD)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tgt       (tgt),
        .ap_rst_n  (ap_rst_n),
        .btn_held  (btn_held),
        .force_req (force_req),
        .wait_zero (wait_zero),
        .hold_zero (hold_zero),
        .wait_ld   (wait_ld),
        .wait_val  (wait_val),
        .hold_ld   (hold_ld),
        .hold_val  (hold_val),
        .state     (st),
        .sys_rst_n (sys_rst_n),
        .pmic_en_n (pmic_en_n),
        .stb       (stb)
    );

    assign state_o    = st;
    assign startup_o  = stb.startup;
    assign resume_o   = stb.resume;
    assign suspend_o  = stb.suspend;
    assign shutdown_o = stb.shutdown;
endmodule

// File: tb/test_pwr_seq_top.sv
`timescale 1ns/1ps
module test_pwr_seq_top;
    localparam int TPM = 2;
    localparam int NS = TPM * 50;
    localparam int NP = TPM * 50;
    localparam int NW = TPM * 300;
    localparam int NB = TPM * 500;
    localparam int NR = TPM * 1000;
    localparam int NH = TPM * 9000;

    logic clk = 1'b0;
    logic rst, ap_rst_n, ap_sleep_n, btn_held, force_req;
    logic sys_rst_n, pmic_en_n, startup_o, resume_o, suspend_o, shutdown_o;
    logic [3:0] state_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit model_live = 1'b0;

    always #10 clk = ~clk;

    pwr_seq_top #(.TICKS_PER_MS(TPM)) i_pwr_seq_top (
        .clk(clk), .rst(rst), .ap_rst_n(ap_rst_n), .ap_sleep_n(ap_sleep_n),
        .btn_held(btn_held), .force_req(force_req),
        .sys_rst_n(sys_rst_n), .pmic_en_n(pmic_en_n), .state_o(state_o),
        .startup_o(startup_o), .resume_o(resume_o),
        .suspend_o(suspend_o), .shutdown_o(shutdown_o)
    );

    // behavioural reference: phase number, up-counting time in phase, hold age
    int  m_st, m_el, m_hel;
    bit  m_rstn, m_pseq, m_hold;
    bit [3:0] m_stb; // {startup,resume,suspend,shutdown}
    int  t, ns, nel, nhel;
    bit  fi, nrstn, npseq, nhold;
    bit [3:0] nstb;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_el = 0; m_hel = 0;
            m_rstn = 0; m_pseq = 1; m_hold = 0; m_stb = 0;
            model_live = 1'b1;
        end else begin
            t = !ap_rst_n ? 0 : (!ap_sleep_n ? 1 : 2);
            ns = m_st; nel = m_el + 1; nstb = 0; fi = 0;
            nrstn = m_rstn; npseq = m_pseq; nhold = m_hold; nhel = m_hel + 1;
            if (m_hold && m_hel == NH - 1) nhold = 0;
            case (m_st)
                0:  if (t != 0) begin ns = 1; nhold = 0; end
                1:  ns = 2;
                2:  begin ns = 3; nrstn = 1; nel = 0; end
                3:  if (m_el == NS - 1) begin ns = 4; npseq = 0; nel = 0; end
                4:  if (m_el == NP - 1) begin ns = 5; npseq = 1; nel = 0; end
                5:  if (ap_rst_n) begin ns = 6; nel = 0; end
                    else if (m_el == NW - 1) ns = 12;
                6:  if (m_el == NB - 1) begin ns = 7; nstb = 4'b1000; end
                7:  if (t == 0) ns = 11;
                    else if (t == 2) begin ns = 8; nel = 0; end
                8:  if (ap_rst_n) begin ns = 9; nstb = 4'b0100; end
                    else if (m_el == NR - 1) begin ns = 10; fi = 1; end
                9:  if (t != 2) ns = 10;
                10: begin ns = 7; nstb = 4'b0010; fi = btn_held; end
                11: begin ns = 12; nstb = 4'b0001; end
                12: ns = 0;
                default: ns = 0;
            endcase
            if (force_req || fi) begin nrstn = 0; nhold = 1; nhel = 0; end
            m_st = ns; m_el = nel; m_stb = nstb;
            m_rstn = nrstn; m_pseq = npseq; m_hold = nhold; m_hel = nhel;
        end
    end

    function automatic string tag_of(int s, bit hold);
        if (hold) return "R12";
        case (s)
            0: return "R2";
            1, 2: return "R3";
            3, 4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            9, 10: return "R9";
            default: return "R11";
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (model_live && !done) begin
            logic [9:0] act, exp;
            act = {state_o, sys_rst_n, pmic_en_n, startup_o, resume_o, suspend_o, shutdown_o};
            exp = {m_st[3:0], m_rstn, m_pseq & ~m_hold, m_stb};
            checks++;
            if (act !== exp) begin
                errors++;
                $display("FAIL %s model compare: actual=%b expected=%b", tag_of(m_st, m_hold), act, exp);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_for(int s, string tag);
        int n = 0;
        while (state_o != s[3:0] && n < 30000) begin
            @(negedge clk);
            n++;
        end
        chk(tag, state_o, s);
    endtask

    task automatic span(int s, output int n);
        n = 0;
        while (state_o == s[3:0] && n < 30000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        rst = 1; ap_rst_n = 0; ap_sleep_n = 0; btn_held = 0; force_req = 0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 state", state_o, 0);
        chk("R1 sys_rst_n", sys_rst_n, 0);
        chk("R1 pmic_en_n", pmic_en_n, 1);
        rst = 0;
        @(negedge clk);
        chk("R1 strobes", {startup_o, resume_o, suspend_o, shutdown_o}, 0);
        chk("R1 state after", state_o, 0);

        // R2: reset asserted outranks sleep, stays in G3
        repeat (20) @(negedge clk);
        chk("R2 hold G3", state_o, 0);

        // normal power-up with a fast processor
        ap_rst_n = 1;
        @(negedge clk);
        chk("R3 leave G3", state_o, 1);
        @(negedge clk);
        chk("R3 soft off", state_o, 2);
        @(negedge clk);
        chk("R3 settle", state_o, 3);
        chk("R4 reset released", sys_rst_n, 1);
        span(3, n);
        chk("R4 settle length", n, NS);
        chk("R4 enable low", pmic_en_n, 0);
        span(4, n);
        chk("R4 pulse length", n, NP);
        chk("R4 enable released", pmic_en_n, 1);
        wait_for(6, "R6 boot");
        span(6, n);
        chk("R6 boot length", n, NB);
        chk("R6 startup strobe", startup_o, 1);
        chk("R6 into S3", state_o, 7);
        repeat (10) @(negedge clk);
        chk("R7 stay S3", state_o, 7);
        ap_sleep_n = 1;
        wait_for(9, "R8 into S0");
        chk("R8 resume strobe", resume_o, 1);

        // suspend and shutdown
        ap_sleep_n = 0;
        wait_for(10, "R9 leave S0");
        @(negedge clk);
        chk("R9 into S3", state_o, 7);
        chk("R9 suspend strobe", suspend_o, 1);
        chk("R10 no button no force", pmic_en_n, 1);
        ap_rst_n = 0;
        wait_for(11, "R7 to S3S5");
        @(negedge clk);
        chk("R11 S5G3", state_o, 12);
        chk("R11 shutdown strobe", shutdown_o, 1);
        @(negedge clk);
        chk("R11 G3", state_o, 0);

        // late processor: reset never released
        ap_rst_n = 1;
        wait_for(3, "R5 start");
        ap_rst_n = 0;
        wait_for(5, "R5 wait");
        span(5, n);
        chk("R5 wait length", n, NW);
        chk("R5 fallback", state_o, 12);
        chk("R5 no strobe", shutdown_o, 0);
        @(negedge clk);
        chk("R5 back to G3", state_o, 0);

        // release in the middle of the wait
        ap_rst_n = 1;
        wait_for(3, "R6 start");
        ap_rst_n = 0;
        wait_for(5, "R6 wait");
        repeat (100) @(negedge clk);
        chk("R5 still waiting", state_o, 5);
        ap_rst_n = 1;
        wait_for(7, "R6 reach S3");

        // resume timeout forces shutdown
        ap_sleep_n = 1;
        @(negedge clk);
        chk("R7 to S3S0", state_o, 8);
        ap_rst_n = 0;
        span(8, n);
        chk("R8 wait length", n, NR);
        chk("R8 to S0S3", state_o, 10);
        chk("R12 reset low", sys_rst_n, 0);
        n = 0;
        while (pmic_en_n == 0 && n < 30000) begin
            n++;
            @(negedge clk);
        end
        chk("R12 hold length", n, NH);
        chk("R12 reset stays low", sys_rst_n, 0);
        chk("R12 in G3", state_o, 0);

        // button held at suspend entry, then hold cancelled by power-up
        ap_rst_n = 1; ap_sleep_n = 1;
        wait_for(9, "R10 reach S0");
        btn_held = 1; ap_sleep_n = 0;
        wait_for(7, "R10 into S3");
        chk("R10 force reset", sys_rst_n, 0);
        chk("R10 force enable", pmic_en_n, 0);
        btn_held = 0; ap_rst_n = 0;
        wait_for(0, "R10 to G3");
        chk("R13 hold running", pmic_en_n, 0);
        ap_rst_n = 1;
        @(negedge clk);
        chk("R13 state", state_o, 1);
        chk("R13 hold ended", pmic_en_n, 1);
        chk("R12 reset still low", sys_rst_n, 0);

        // external force request in S0
        ap_sleep_n = 1;
        wait_for(9, "R12 reach S0");
        force_req = 1;
        @(negedge clk);
        force_req = 0;
        chk("R12 ext force reset", sys_rst_n, 0);
        chk("R12 ext force enable", pmic_en_n, 0);
        ap_rst_n = 0;
        wait_for(0, "R12 to G3");
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule